// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block decides where each memory access below 1 MiB goes. It holds a small set of configuration bytes. For each incoming physical address and its read/write direction, it selects one of three targets: ordinary DRAM, DRAM that may only be read, or the PCI bus. The region from 0xF0000 up to 1 MiB is one 64 KiB attribute segment. The region from 0xC0000 to 0xEFFFF is cut into twelve 16 KiB segments, and each segment has its own two-bit attribute. The 128 KiB window at 0xA0000–0xBFFFF is steered by a system-management RAM control byte, qualified by the system-management-mode input. Addresses below 0xA0000 always reach DRAM.

Software programs the configuration bytes through a byte-wide write port and reads them back through a combinational read port. The decode is combinational from the stored bytes, so a new mapping applies from the cycle after the write. The system-management-mode input acts on the window in the same cycle it changes. If a write lands on a read-only segment, the block does not send it to DRAM and raises a write-blocked flag.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset, every attribute byte (0x59–0x5F) reads 0x00, the SMRAM control byte (0x72) reads 0x02 and the DRAM size byte (0x57) reads 0x08. Consequently the BIOS segments, the expansion segments and the 0xA0000 window all decode to PCI.
- R2: A write to 0x57, 0x59–0x5F or 0x72 is read back in full on `cfgRdData` when `cfgAddr` selects that byte. Any other offset reads 0x00, and writes to it have no effect.
- R3: Any address below 0xA0000 selects DRAM (target code 0) and never raises `writeBlocked`.
- R4: Target codes are 0 = DRAM, 1 = read-only DRAM, 2 = PCI; code 3 never appears. A two-bit attribute decodes as follows: 0 and 2 select PCI, 1 selects read-only DRAM, 3 selects DRAM.
- R5: Bits [5:4] of byte 0x59 give the attribute of 0xF0000–0xFFFFF. Segment i (0..11) covers 0xC0000 + i·0x4000 for 16 KiB. It takes its attribute from byte 0x5A + (i>>1), bits [1:0] when i is even and bits [5:4] when i is odd.
- R6: A write to a read-only segment selects PCI. It raises `writeBlocked` only while `memValid` is high. `writeBlocked` is low in every other case, and a read of such a segment selects code 1.
- R7: The 0xA0000–0xBFFFF window selects DRAM for reads and writes when bit 6 of byte 0x72 is set, or when `smmActive` is high and bit 3 is set. Otherwise it selects PCI.
- R8: A change of `smmActive` alters the window decode in the same cycle, with no clock edge.
- R9: A configuration write changes the decode only after the clock edge that stores it; in the cycle of the write the old mapping is still output.
- R10: Bits [3:2] and [7:6] of the attribute bytes have no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset for read and write |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for `cfgAddr` |
| smmActive | input | 1 | System-management mode is active |
| memValid | input | 1 | An access is presented this cycle |
| memWrite | input | 1 | 1 = write access, 0 = read access |
| memAddr | input | 20 | Physical address of the access |
| target | output | 2 | Selected target: 0 DRAM, 1 read-only DRAM, 2 PCI |
| writeBlocked | output | 1 | A valid write hit a read-only segment |

## Verification
Several properties are checked on every cycle:
- low memory always reaches DRAM unblocked;
- the blocked flag only accompanies a valid write that was sent to PCI;
- the target code is never 3;
- a write that opens the window, or makes the high BIOS segment writable, takes hold on the next cycle;
- a stored SMRAM byte reads back.

Other behaviours need the bench's scenarios:
- the exact segment-to-field mapping across all twelve segments;
- the same-cycle effect of the system-management input;
- the fact that a write is invisible during its own cycle;
- the irrelevance of the unused attribute bits and unmapped offsets.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  localparam int ATTR_BYTES = 7;

  typedef enum logic [1:0] {
    TGT_DRAM    = 2'd0,
    TGT_DRAM_RO = 2'd1,
    TGT_PCI     = 2'd2
  } target_e;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic [ATTR_BYTES-1:0] attrWe;
    logic [ATTR_BYTES-1:0] attrRd;
    logic                  smramWe;
    logic                  smramRd;
    logic                  sizeWe;
    logic                  sizeRd;
  } cfg_strobe_t;

  // two-bit segment attribute to target, write direction aware
  function automatic target_e attr_to_target(input logic [1:0] attr, input logic isWrite);
    target_e t;
    case (attr)
      2'd3:    t = TGT_DRAM;
      2'd1:    t = isWrite ? TGT_PCI : TGT_DRAM_RO;
      default: t = TGT_PCI;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/lmd_ctrl.sv
module lmd_ctrl
  import lmd_pkg::*;
#(
  parameter logic [7:0] ATTR_BASE = 8'h59,
  parameter logic [7:0] SMRAM_OFF = 8'h72,
  parameter logic [7:0] SIZE_OFF  = 8'h57
) (
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  output cfg_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    for (int i = 0; i < ATTR_BYTES; i++) begin
      if (cfgAddr == ATTR_BASE + 8'(i)) begin
        strobe.attrRd[i] = 1'b1;
        strobe.attrWe[i] = cfgWrEn;
      end
    end
    if (cfgAddr == SMRAM_OFF) begin
      strobe.smramRd = 1'b1;
      strobe.smramWe = cfgWrEn;
    end
    if (cfgAddr == SIZE_OFF) begin
      strobe.sizeRd = 1'b1;
      strobe.sizeWe = cfgWrEn;
    end
  end

endmodule

// File: rtl/lmd_datapath.sv
module lmd_datapath
  import lmd_pkg::*;
#(
  parameter logic [7:0] SMRAM_RESET = 8'h02,
  parameter logic [7:0] SIZE_RESET  = 8'h08,
  parameter int         SEG_COUNT   = 12,
  parameter int         ADDR_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_strobe_t       strobe,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              smmActive,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        target,
  output logic              writeBlocked
);

  localparam int SEG_SHIFT = 14;
  localparam int IDX_W     = ADDR_W - 2 - SEG_SHIFT;
  localparam int SMRAM_OPEN_BIT = 6;
  localparam int SMRAM_SMM_BIT  = 3;

  logic [7:0] attrReg [ATTR_BYTES];
  logic [7:0] smramReg;
  logic [7:0] sizeReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ATTR_BYTES; i++) attrReg[i] <= 8'h00;
      smramReg <= SMRAM_RESET;
      sizeReg  <= SIZE_RESET;
    end else begin
      for (int i = 0; i < ATTR_BYTES; i++)
        if (strobe.attrWe[i]) attrReg[i] <= cfgWrData;
      if (strobe.smramWe) smramReg <= cfgWrData;
      if (strobe.sizeWe)  sizeReg  <= cfgWrData;
    end
  end

  always_comb begin
    cfgRdData = 8'h00;
    for (int i = 0; i < ATTR_BYTES; i++)
      if (strobe.attrRd[i]) cfgRdData = attrReg[i];
    if (strobe.smramRd) cfgRdData = smramReg;
    if (strobe.sizeRd)  cfgRdData = sizeReg;
  end

  // per-segment attribute fields, two per byte after the first
  logic [1:0] segAttr [SEG_COUNT];
  for (genvar g = 0; g < SEG_COUNT; g++) begin : gSeg
    assign segAttr[g] = attrReg[1 + g/2][(g%2)*4 +: 2];
  end

  logic             inBios, inSeg, inWin;
  logic [IDX_W-1:0] segIdx;
  logic [1:0]       segSel;
  logic             winOpen;
  target_e          tgt;

  assign inBios  = memAddr[ADDR_W-1 -: 4] == 4'hF;
  assign inSeg   = memAddr[ADDR_W-1 -: 2] == 2'b11 && !inBios;
  assign inWin   = memAddr[ADDR_W-1 -: 3] == 3'b101;
  assign segIdx  = memAddr[SEG_SHIFT +: IDX_W];
  assign winOpen = smramReg[SMRAM_OPEN_BIT] | (smmActive & smramReg[SMRAM_SMM_BIT]);

  always_comb begin
    segSel = 2'd0;
    for (int k = 0; k < SEG_COUNT; k++)
      if (segIdx == IDX_W'(k)) segSel = segAttr[k];
  end

  always_comb begin
    if (inBios)      tgt = attr_to_target(attrReg[0][5:4], memWrite);
    else if (inSeg)  tgt = attr_to_target(segSel, memWrite);
    else if (inWin)  tgt = winOpen ? TGT_DRAM : TGT_PCI;
    else             tgt = TGT_DRAM;
  end

  logic roHit;
  always_comb begin
    if (inBios)     roHit = attrReg[0][5:4] == 2'd1;
    else if (inSeg) roHit = segSel == 2'd1;
    else            roHit = 1'b0;
  end

  assign target       = tgt;
  assign writeBlocked = memValid & memWrite & roHit;

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import lmd_pkg::*;
#(
  parameter logic [7:0] ATTR_BASE   = 8'h59,
  parameter logic [7:0] SMRAM_OFF   = 8'h72,
  parameter logic [7:0] SIZE_OFF    = 8'h57,
  parameter logic [7:0] SMRAM_RESET = 8'h02,
  parameter logic [7:0] SIZE_RESET  = 8'h08,
  parameter int         SEG_COUNT   = 12,
  parameter int         ADDR_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              smmActive,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        target,
  output logic              writeBlocked
);

  cfg_strobe_t strobe;

  lmd_ctrl #(
    .ATTR_BASE(ATTR_BASE), .SMRAM_OFF(SMRAM_OFF), .SIZE_OFF(SIZE_OFF)
  ) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .strobe(strobe)
  );

  lmd_datapath #(
    .SMRAM_RESET(SMRAM_RESET), .SIZE_RESET(SIZE_RESET),
    .SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .smmActive(smmActive), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .target(target),
    .writeBlocked(writeBlocked)
  );

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
  parameter logic [7:0] ATTR_BASE = 8'h59,
  parameter logic [7:0] SMRAM_OFF = 8'h72
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfgWrEn,
  input logic [7:0]  cfgAddr,
  input logic [7:0]  cfgWrData,
  input logic [7:0]  cfgRdData,
  input logic        smmActive,
  input logic        memValid,
  input logic        memWrite,
  input logic [19:0] memAddr,
  input logic [1:0]  target,
  input logic        writeBlocked
);

  a_r3_low_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (memAddr < 20'hA0000) |-> (target == 2'd0 && !writeBlocked));

  a_r6_block_cause: assert property (@(posedge clk) disable iff (!rst_n)
    writeBlocked |-> (memValid && memWrite && target == 2'd2));

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    target != 2'd3);

  a_r7_open_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr == SMRAM_OFF && cfgWrData[6])
      |=> (memAddr[19:17] != 3'b101 || target == 2'd0));

  a_r2_smram_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr == SMRAM_OFF)
      |=> (cfgAddr != SMRAM_OFF || cfgRdData == $past(cfgWrData)));

  a_r5_bios_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr == ATTR_BASE && cfgWrData[5:4] == 2'b11)
      |=> (memAddr[19:16] != 4'hF || (target == 2'd0 && !writeBlocked)));

endmodule

bind legacy_mem_decoder lmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .smmActive(smmActive),
  .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .target(target), .writeBlocked(writeBlocked)
);

// File: tb/sim_legacy_mem_decoder.sv
module sim_legacy_mem_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        smmActive = 1'b0;
  logic        memValid = 1'b0;
  logic        memWrite = 1'b0;
  logic [19:0] memAddr = 20'h0;
  logic [1:0]  target;
  logic        writeBlocked;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  legacy_mem_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .smmActive(smmActive),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .target(target), .writeBlocked(writeBlocked)
  );

  // {addr, write, smm, expected target, expected blocked}
  localparam int NV = 20;
  localparam logic [24:0] VEC [NV] = '{
    {20'h00000, 1'b0, 1'b0, 2'd0, 1'b0},  // R3
    {20'h9FFFF, 1'b1, 1'b0, 2'd0, 1'b0},  // R3
    {20'hA0000, 1'b0, 1'b0, 2'd2, 1'b0},  // R7 closed
    {20'hBFFFF, 1'b0, 1'b1, 2'd0, 1'b0},  // R7 smm + bit3
    {20'hB0000, 1'b1, 1'b1, 2'd0, 1'b0},  // R7 write
    {20'hC0000, 1'b0, 1'b0, 2'd1, 1'b0},  // R5 seg0 ro
    {20'hC3FFF, 1'b1, 1'b0, 2'd2, 1'b1},  // R6 seg0 write
    {20'hC4000, 1'b1, 1'b0, 2'd0, 1'b0},  // R5 seg1 rw
    {20'hC8000, 1'b0, 1'b0, 2'd2, 1'b0},  // R5 seg2 attr0
    {20'hCC000, 1'b0, 1'b0, 2'd2, 1'b0},  // R4 seg3 attr2
    {20'hD0000, 1'b1, 1'b0, 2'd0, 1'b0},  // R5 seg4
    {20'hD4000, 1'b0, 1'b0, 2'd1, 1'b0},  // R5 seg5
    {20'hD8000, 1'b0, 1'b0, 2'd2, 1'b0},  // R10 seg6 attr2 with noise bits
    {20'hDC000, 1'b1, 1'b0, 2'd0, 1'b0},  // R10 seg7 rw with noise bits
    {20'hE0000, 1'b1, 1'b0, 2'd2, 1'b1},  // R6 seg8
    {20'hE4000, 1'b0, 1'b0, 2'd2, 1'b0},  // R5 seg9
    {20'hE8000, 1'b0, 1'b0, 2'd0, 1'b0},  // R5 seg10
    {20'hEFFFF, 1'b1, 1'b0, 2'd2, 1'b1},  // R6 seg11
    {20'hF0000, 1'b1, 1'b0, 2'd0, 1'b0},  // R5 bios rw
    {20'hFFFFF, 1'b0, 1'b0, 2'd0, 1'b0}   // R5 bios end
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic probe(input logic [19:0] a, input logic w, input logic s);
    memAddr = a; memWrite = w; smmActive = s; memValid = 1'b1;
    #1;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_read(8'h59, rd); check("R1 attr 0x59", rd, 8'h00);
    cfg_read(8'h5F, rd); check("R1 attr 0x5F", rd, 8'h00);
    cfg_read(8'h72, rd); check("R1 smram", rd, 8'h02);
    cfg_read(8'h57, rd); check("R1 size", rd, 8'h08);
    probe(20'hF0000, 1'b0, 1'b0); check("R1 bios pci", target, 2);
    probe(20'hC0000, 1'b0, 1'b0); check("R1 seg pci", target, 2);
    probe(20'hA0000, 1'b0, 1'b1); check("R1 window pci", target, 2);

    // R9 write visible only after the storing edge
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h72; cfgWrData = 8'h40;
    probe(20'hA0000, 1'b0, 1'b0);
    check("R9 old mapping", target, 2);
    @(posedge clk); #1;
    check("R9 new mapping", target, 0);
    @(negedge clk); cfgWrEn = 1'b0;

    // configuration for the table, with noise bits for R10
    cfg_write(8'h59, 8'hF0);
    cfg_write(8'h5A, 8'h31);
    cfg_write(8'h5B, 8'h20);
    cfg_write(8'h5C, 8'h13);
    cfg_write(8'h5D, 8'hFE);
    cfg_write(8'h5E, 8'h01);
    cfg_write(8'h5F, 8'h13);
    cfg_write(8'h72, 8'h08);
    cfg_read(8'h5D, rd); check("R2 attr readback", rd, 8'hFE);
    cfg_read(8'h72, rd); check("R2 smram readback", rd, 8'h08);

    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][24:5], VEC[i][4], VEC[i][3]);
      check($sformatf("R5 vec%0d target", i), target, VEC[i][2:1]);
      check($sformatf("R6 vec%0d blocked", i), writeBlocked, VEC[i][0]);
    end

    // R8 smm input acts without a clock edge
    probe(20'hA8000, 1'b0, 1'b0); check("R8 smm low", target, 2);
    smmActive = 1'b1; #1;         check("R8 smm high", target, 0);
    smmActive = 1'b0; #1;         check("R8 smm low again", target, 2);

    // R6 no flag without a valid access
    probe(20'hC0000, 1'b1, 1'b0);
    memValid = 1'b0; #1;
    check("R6 invalid no flag", writeBlocked, 0);
    check("R6 invalid target", target, 2);
    memValid = 1'b1;

    // R10 only bits 5:4 of the first byte steer the bios segment
    cfg_write(8'h59, 8'hCF);
    probe(20'hF8000, 1'b0, 1'b0); check("R10 bios noise", target, 2);
    cfg_write(8'h59, 8'h10);
    probe(20'hF8000, 1'b0, 1'b0); check("R4 bios ro read", target, 1);
    probe(20'hF8000, 1'b1, 1'b0); check("R6 bios ro write", writeBlocked, 1);

    // R2 unmapped offset ignored, size byte writable
    cfg_write(8'h60, 8'hAA);
    cfg_read(8'h60, rd); check("R2 unmapped reads zero", rd, 8'h00);
    probe(20'hF8000, 1'b0, 1'b0); check("R2 unmapped no effect", target, 1);
    cfg_write(8'h57, 8'h10);
    cfg_read(8'h57, rd); check("R2 size readback", rd, 8'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule